// File: doc/BRIEF.md
# BCD Time-of-Day and Day Counter

This block keeps wall-clock time for a chip that has a one-second tick. Seconds, minutes and hours are kept in packed BCD, so software can show them with no conversion. Elapsed days are kept in a plain binary count, and the conversion to a calendar date is left to software. A one-cycle pulse on `tick_i` moves the time forward by one second, but only while the run bit in the control register is set.

Software reaches the counter through a byte-wide register port. The write is synchronous and the read is combinational. Each counted tick and each accepted write starts a short busy window. Software polls the busy flag in the control register before each access, and a write made while the flag is high is dropped. To set the time, software writes seconds, minutes, hours, the low day byte and the high day byte in that order, waiting for the busy flag to clear before each write, and then sets the run bit.

Top module: `bcd_tod_counter`

## Requirements
- R1: After reset every register reads 0x00: the time fields, the day bytes and the control register, which means counting is stopped and the busy flag is clear.
- R2: Seconds read at address 0x15 as packed BCD (tens in bits 6:4, units in bits 3:0). Each counted tick adds one: units 9 carries into the tens, and 0x59 goes to 0x00 with a carry into minutes.
- R3: Minutes read at address 0x16 in the same BCD form. A carry in adds one, and 0x59 goes to 0x00 with a carry into hours.
- R4: Hours read at address 0x17 in BCD (bits 5:0). A carry in adds one, and 0x23 goes to 0x00 with a one-step increment of the day count.
- R5: The day count is a 15-bit binary value. Bits 7:0 are at address 0x18 and bits 14:8 are at address 0x19, bits 6:0 (bit 7 reads 0). It wraps from 0x7FFF to 0x0000.
- R6: The control register is at address 0x14. Bit 0 is the run enable, and while it is 0 a tick changes no field.
- R7: Control bit 7 is a read-only busy flag. It is 1 for exactly BUSY_CYCLES (default 3) cycles after each counted tick and after each accepted write. Writing bit 7 has no effect.
- R8: A write presented while the busy flag is 1 is ignored and changes no register.
- R9: A tick that comes in the same cycle as an accepted write is not lost. It is applied in the next cycle, after the written value is in place.
- R10: A write to an address outside 0x14 to 0x19 changes no register, and reads of such an address return 0x00.
- R11: A write accepted at a clock edge shows in the read data of the written address from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse, one per second |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Register address, shared by reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |

## Verification
A second tick and a register write can land on the same clock edge, since a tick arrives at any time relative to software. The bench drives `wr_i` and `tick_i` on the same edge while the block is idle and counting. It then reads the written field one cycle later, expecting the raw written value, and again a cycle after that, expecting that value advanced by one second. This shows the tick was deferred rather than dropped or merged. Constrained-random runs set random legal times near rollover boundaries and tick many times, and each field is compared with a bench model of the BCD cascade.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [7:0] ADDR_CTRL  = 8'h14;
  localparam logic [7:0] ADDR_SEC   = 8'h15;
  localparam logic [7:0] ADDR_MIN   = 8'h16;
  localparam logic [7:0] ADDR_HOUR  = 8'h17;
  localparam logic [7:0] ADDR_DAYLO = 8'h18;
  localparam logic [7:0] ADDR_DAYHI = 8'h19;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_BUSY_BIT = 7;
endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
  parameter int           W     = 7,
  parameter logic [W-1:0] LIMIT = 7'h59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q, val_d;
  logic         upd;

  assign upd = ld_i | inc_i;

  always_comb begin
    val_d = val_q;
    if (ld_i) begin
      val_d = ld_val_i;
    end else if (inc_i) begin
      if (val_q == LIMIT)            val_d = '0;
      else if (val_q[3:0] == 4'd9)   val_d = {val_q[W-1:4] + 1'b1, 4'd0};
      else                           val_d = val_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= '0;
    else if (upd) val_q <= val_d;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i & ~ld_i & (val_q == LIMIT);
endmodule

// File: rtl/tod_day_counter.sv
module tod_day_counter #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [7:0]       data_i,
  output logic [DAY_W-1:0] day_o
);
  localparam int HI_W = DAY_W - 8;

  logic [DAY_W-1:0] day_q, day_d;
  logic             upd;

  assign upd = inc_i | ld_lo_i | ld_hi_i;

  always_comb begin
    day_d = day_q;
    if (ld_lo_i)      day_d[7:0]       = data_i;
    else if (ld_hi_i) day_d[DAY_W-1:8] = data_i[HI_W-1:0];
    else if (inc_i)   day_d            = day_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   day_q <= '0;
    else if (upd) day_q <= day_d;
  end

  assign day_o = day_q;
endmodule

// File: rtl/tod_busy_timer.sv
module tod_busy_timer #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign busy_o = (cnt_q != '0);
  assign upd    = start_i | busy_o;

  always_comb begin
    if (start_i)     cnt_d = CNT_W'(CYCLES);
    else if (busy_o) cnt_d = cnt_q - 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bcd_tod_counter.sv
module bcd_tod_counter
  import tod_pkg::*;
#(
  parameter int BUSY_CYCLES = 3,
  parameter int DAY_W       = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              busy, wr_acc, advance;
  logic              en_q, en_d, pend_q, pend_d;
  logic              hit_ctrl, hit_sec, hit_min, hit_hour, hit_dlo, hit_dhi;
  logic              sec_wrap, min_wrap, hour_wrap;
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [DAY_W-1:0]  day_q;

  assign wr_acc   = wr_i & ~busy;
  assign hit_ctrl = wr_acc & (addr_i == ADDR_CTRL);
  assign hit_sec  = wr_acc & (addr_i == ADDR_SEC);
  assign hit_min  = wr_acc & (addr_i == ADDR_MIN);
  assign hit_hour = wr_acc & (addr_i == ADDR_HOUR);
  assign hit_dlo  = wr_acc & (addr_i == ADDR_DAYLO);
  assign hit_dhi  = wr_acc & (addr_i == ADDR_DAYHI);

  // a tick colliding with an accepted write is held one cycle
  assign advance = (tick_i | pend_q) & en_q & ~wr_acc;
  assign pend_d  = (tick_i | pend_q) & en_q &  wr_acc;
  assign en_d    = hit_ctrl ? wdata_i[CTRL_RUN_BIT] : en_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  tod_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_int_n), .start_i(advance | wr_acc), .busy_o(busy)
  );

  tod_bcd_field #(.W(SEC_W), .LIMIT(7'h59)) u_sec (
    .clk(clk), .rst_n(rst_int_n), .inc_i(advance), .ld_i(hit_sec),
    .ld_val_i(wdata_i[SEC_W-1:0]), .val_o(sec_q), .wrap_o(sec_wrap)
  );

  tod_bcd_field #(.W(MIN_W), .LIMIT(7'h59)) u_min (
    .clk(clk), .rst_n(rst_int_n), .inc_i(sec_wrap), .ld_i(hit_min),
    .ld_val_i(wdata_i[MIN_W-1:0]), .val_o(min_q), .wrap_o(min_wrap)
  );

  tod_bcd_field #(.W(HOUR_W), .LIMIT(6'h23)) u_hour (
    .clk(clk), .rst_n(rst_int_n), .inc_i(min_wrap), .ld_i(hit_hour),
    .ld_val_i(wdata_i[HOUR_W-1:0]), .val_o(hour_q), .wrap_o(hour_wrap)
  );

  tod_day_counter #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_int_n), .inc_i(hour_wrap), .ld_lo_i(hit_dlo),
    .ld_hi_i(hit_dhi), .data_i(wdata_i), .day_o(day_q)
  );

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_RUN_BIT]  = en_q;
        rdata_o[CTRL_BUSY_BIT] = busy;
      end
      ADDR_SEC:   rdata_o = 8'(sec_q);
      ADDR_MIN:   rdata_o = 8'(min_q);
      ADDR_HOUR:  rdata_o = 8'(hour_q);
      ADDR_DAYLO: rdata_o = day_q[7:0];
      ADDR_DAYHI: rdata_o = 8'(day_q[DAY_W-1:8]);
      default:    rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/tod_counter_checker.sv
module tod_counter_checker
  import tod_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_i,
  input logic [7:0] addr_i,
  input logic       busy,
  input logic       en_q,
  input logic       pend_q,
  input logic [6:0] sec_q,
  input logic [5:0] hour_q
);
  a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q <= 7'h59) && (sec_q[3:0] <= 4'd9));

  a_r4_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    hour_q <= 6'h23);

  a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_i) |=> ($stable(sec_q) && $stable(hour_q)));

  a_r7_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_i && !wr_i) |=> busy);

  a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_i && addr_i == ADDR_SEC && !(en_q && (tick_i || pend_q)))
      |=> $stable(sec_q));

  a_r9_pending_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy);
endmodule

bind bcd_tod_counter tod_counter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i), .addr_i(addr_i),
  .busy(busy), .en_q(en_q), .pend_q(pend_q), .sec_q(sec_q), .hour_q(hour_q)
);

// File: tb/bcd_tod_counter_bench.sv
module bcd_tod_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY_N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // model state (binary)
  int m_s, m_m, m_h, m_d;
  bit m_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_tod_counter #(.BUSY_CYCLES(BUSY_N)) u_bcd_tod_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic void model_step();
    m_s++;
    if (m_s == 60) begin m_s = 0; m_m++; end
    if (m_m == 60) begin m_m = 0; m_h++; end
    if (m_h == 24) begin m_h = 0; m_d = (m_d + 1) & 16'h7FFF; end
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // combinational read; caller sits just after a falling edge
  task automatic rd(input logic [7:0] a, output int v);
    addr_i = a;
    #1;
    v = int'(rdata_o);
  endtask

  task automatic wait_idle();
    int c;
    rd(8'h14, c);
    while (c[7]) begin
      @(negedge clk);
      rd(8'h14, c);
    end
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wait_idle();
    wr_raw(a, d);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    if (m_en) model_step();
  endtask

  task automatic set_time(int h, int m, int s, int d);
    wr(8'h15, 8'(to_bcd(s)));
    wr(8'h16, 8'(to_bcd(m)));
    wr(8'h17, 8'(to_bcd(h)));
    wr(8'h18, 8'(d & 8'hFF));
    wr(8'h19, 8'((d >> 8) & 8'h7F));
    m_s = s; m_m = m; m_h = h; m_d = d;
  endtask

  task automatic set_run(bit e);
    wr(8'h14, {7'd0, e});
    m_en = e;
  endtask

  task automatic cmp_all(string tag);
    int v;
    wait_idle();
    rd(8'h15, v); check({tag, " R2 sec"}, v, to_bcd(m_s));
    rd(8'h16, v); check({tag, " R3 min"}, v, to_bcd(m_m));
    rd(8'h17, v); check({tag, " R4 hour"}, v, to_bcd(m_h));
    rd(8'h18, v); check({tag, " R5 daylo"}, v, m_d & 8'hFF);
    rd(8'h19, v); check({tag, " R5 dayhi"}, v, (m_d >> 8) & 8'h7F);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    m_s = 0; m_m = 0; m_h = 0; m_d = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(8'h14, v); check("R1 ctrl", v, 0);
    cmp_all("R1");

    // R11: readback, R7 busy window
    wr(8'h15, 8'h42);
    rd(8'h14, v); check("R7 busy set", v & 8'h80, 8'h80);
    @(negedge clk); @(negedge clk);
    rd(8'h14, v); check("R7 busy last cycle", v & 8'h80, 8'h80);
    @(negedge clk);
    rd(8'h14, v); check("R7 busy clear", v & 8'h80, 0);
    rd(8'h15, v); check("R11 readback", v, 8'h42);

    // R8: write during busy dropped
    wr(8'h15, 8'h11);
    wr_raw(8'h15, 8'h22);
    wait_idle();
    rd(8'h15, v); check("R8 busy write ignored", v, 8'h11);

    // R7: busy bit not writable
    wr(8'h14, 8'h80);
    wait_idle();
    rd(8'h14, v); check("R7 ctrl bit7 read-only", v, 0);

    // R10: unmapped address
    wr(8'h20, 8'hFF);
    wait_idle();
    rd(8'h20, v); check("R10 unmapped read", v, 0);
    rd(8'h15, v); check("R10 no side effect", v, 8'h11);

    // R6: stopped counter ignores ticks
    set_time(5, 6, 7, 9);
    repeat (3) tick();
    cmp_all("R6 stopped");

    // rollover corners
    set_time(0, 0, 9, 0);
    set_run(1);
    tick(); cmp_all("R2 units carry");
    set_time(3, 59, 59, 12);
    tick(); cmp_all("R3 min carry");
    set_time(23, 59, 59, 16'h00FF);
    tick(); cmp_all("R4 day carry into high byte");
    set_time(23, 59, 59, 16'h7FFF);
    tick(); cmp_all("R5 day wrap");

    // R9: tick in the same cycle as an accepted write
    set_time(1, 2, 3, 4);
    wait_idle();
    @(negedge clk);
    wr_i = 1'b1; addr_i = 8'h15; wdata_i = 8'h30; tick_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; tick_i = 1'b0;
    rd(8'h15, v); check("R9 written value first", v, 8'h30);
    @(negedge clk);
    rd(8'h15, v); check("R9 deferred tick applied", v, 8'h31);

    // constrained random: legal times biased near boundaries
    for (int it = 0; it < 20; it++) begin
      int h, m, s, d, n;
      s = ($urandom % 2) ? 50 + ($urandom % 10) : $urandom % 60;
      m = ($urandom % 2) ? 58 + ($urandom % 2) : $urandom % 60;
      h = ($urandom % 2) ? 23 : $urandom % 24;
      d = ($urandom % 3 == 0) ? 16'h7FFF : $urandom % 16'h8000;
      set_run(0);
      set_time(h, m, s, d);
      set_run(1);
      n = 1 + ($urandom % 150);
      for (int k = 0; k < n; k++) begin
        tick();
        if ($urandom % 4 == 0) @(negedge clk);
      end
      cmp_all("R2 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule